// File: doc/BRIEF.md
# Address-Event Frame Readout Capture

The block takes the sparse readout of a 128 x 64 binary difference image. The image is scanned in raster order. For every nonzero pixel the sensor gives a column address and the sign of the difference, together with a valid strobe. The row address is never sent: the block counts end-of-row pulses to rebuild it. Each event becomes a 16-bit halfword. A serial-to-parallel stage then gathers several halfwords into one wide word, so the on-chip FIFO is written at a fraction of the event rate.

Readout is armed by a start command. If the mode input selects active mode, the block captures events until the last end-of-row. At that point it flushes any partly filled word and raises a done flag. If the mode input selects idle mode, no events are stored. The block waits for the single nonzero-pixel total that the sensor delivers at the end of the scan, latches it and reports done.

Top module: `aer_frame_capture`

## Requirements
- R1: After reset, fifo_wr_en, frame_done and overflow are 0 and pix_count is 0.
- R2: Each event is the halfword {2'b00, row[5:0], col[6:0], sign}. EV_PER_WORD halfwords fill one FIFO word, with the earliest event in the most significant halfword. fifo_wr_en pulses for one cycle, in the cycle after the event that completes the word.
- R3: The row of an event equals the number of end-of-row pulses since the start command. An event presented in the same cycle as an end-of-row pulse takes the row before the advance.
- R4: Event strobes and end-of-row pulses are ignored unless an active-mode start command has armed capture. This covers the time before any start and the time after frame_done.
- R5: frame_done rises in the cycle after the 64th end-of-row pulse, never earlier, and stays high until the next start command.
- R6: On the 64th end-of-row pulse, a partly filled word is written in the next cycle, its empty halfwords set to 16'hFFFF. If no event is pending, no extra write occurs.
- R7: When a word completes while fifo_full is high, the word is dropped and overflow becomes 1. overflow stays 1 until the next start command clears it.
- R8: In active mode, pix_count counts every accepted event, including events in dropped words. It is cleared by the start command.
- R9: In idle mode, a cnt_valid pulse loads cnt_value into pix_count and sets frame_done in the next cycle. No FIFO write occurs and event strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_active | input | 1 | 1 = event readout, 0 = count only; sampled at start |
| frame_start | input | 1 | Start command, one-cycle pulse |
| ev_valid | input | 1 | Event strobe |
| ev_col | input | 7 | Column of the event |
| ev_sign | input | 1 | Sign of the difference |
| eor | input | 1 | End-of-row pulse |
| cnt_valid | input | 1 | Idle-mode total is present |
| cnt_value | input | 14 | Idle-mode nonzero-pixel total |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | Packed word |
| pix_count | output | 14 | Event count or latched total |
| frame_done | output | 1 | Frame finished |
| overflow | output | 1 | Sticky drop flag |

## Verification
The bench uses the default parameters: 128 columns, 64 rows and two events per word. A full frame therefore takes only a few hundred cycles, so every scenario can run the real 64-row scan to its end. Two events per word let odd and even event counts tell a flushed padded word from a complete one. They also make a word boundary fall on an event that shares its cycle with an end-of-row pulse.

// File: rtl/aer_capture_pkg.sv
package aer_capture_pkg;
  localparam int HALF_W = 16;
  localparam logic [HALF_W-1:0] PAD_HALF = 16'hFFFF;

  // Halfword layout: {zeros, row, column, sign}
  function automatic logic [HALF_W-1:0] pack_event(input int row, input int col,
                                                   input logic sgn, input int col_w);
    int v;
    v = (row << (col_w + 1)) | (col << 1) | int'(sgn);
    return HALF_W'(v);
  endfunction
endpackage

// File: rtl/aer_row_tracker.sv
module aer_row_tracker #(
  parameter int ROWS  = 64,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [ROW_W-1:0] row,
  output logic             last_eor
);
  logic [ROW_W-1:0] row_q;

  assign last_eor = advance && (row_q == ROW_W'(ROWS - 1));
  assign row      = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row_q <= '0;
    end else if (advance) begin
      row_q <= last_eor ? '0 : row_q + 1'b1;
    end
  end
endmodule

// File: rtl/aer_event_packer.sv
module aer_event_packer
  import aer_capture_pkg::*;
#(
  parameter int EV_PER_WORD = 2,
  parameter int WORD_W      = EV_PER_WORD * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [HALF_W-1:0] ev_half,
  input  logic              flush,
  input  logic              fifo_full,
  output logic              fifo_wr_en,
  output logic [WORD_W-1:0] fifo_wr_data,
  output logic              overflow,
  output logic              word_ready
);
  localparam int FILL_W = $clog2(EV_PER_WORD + 1);

  logic [FILL_W-1:0] fill_q, fill_n;
  logic [HALF_W-1:0] slot_q [EV_PER_WORD];
  logic [HALF_W-1:0] slot_n [EV_PER_WORD];
  logic [WORD_W-1:0] word_n;
  logic              slots_full;

  always_comb begin
    fill_n = fill_q;
    for (int i = 0; i < EV_PER_WORD; i++) slot_n[i] = slot_q[i];
    if (push) begin
      for (int i = 0; i < EV_PER_WORD; i++)
        if (FILL_W'(i) == fill_q) slot_n[i] = ev_half;
      fill_n = fill_q + 1'b1;
    end
    slots_full = (fill_n == FILL_W'(EV_PER_WORD));
    word_ready = slots_full || (flush && (fill_n != '0));
  end

  generate
    for (genvar g = 0; g < EV_PER_WORD; g++) begin : g_lane
      assign word_n[(EV_PER_WORD-1-g)*HALF_W +: HALF_W] =
        (FILL_W'(g) < fill_n) ? slot_n[g] : PAD_HALF;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fill_q       <= '0;
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      overflow     <= 1'b0;
      for (int i = 0; i < EV_PER_WORD; i++) slot_q[i] <= '0;
    end else begin
      fifo_wr_en <= word_ready && !fifo_full;
      if (word_ready) fifo_wr_data <= word_n;
      if (word_ready && fifo_full) overflow <= 1'b1;
      fill_q <= word_ready ? '0 : fill_n;
      for (int i = 0; i < EV_PER_WORD; i++) slot_q[i] <= slot_n[i];
    end
  end
endmodule

// File: rtl/aer_capture_ctrl.sv
module aer_capture_ctrl #(
  parameter int PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_active,
  input  logic             frame_start,
  input  logic             ev_valid,
  input  logic             last_eor,
  input  logic             cnt_valid,
  input  logic [PIX_W-1:0] cnt_value,
  output logic             capturing,
  output logic             accept,
  output logic [PIX_W-1:0] pix_count,
  output logic             frame_done
);
  typedef enum logic [1:0] {ST_WAIT, ST_CAPT, ST_COUNT} cap_state_e;
  cap_state_e state_q;

  assign capturing = (state_q == ST_CAPT) && !frame_start;
  assign accept    = capturing && ev_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      pix_count  <= '0;
      frame_done <= 1'b0;
    end else if (frame_start) begin
      state_q    <= mode_active ? ST_CAPT : ST_COUNT;
      pix_count  <= '0;
      frame_done <= 1'b0;
    end else begin
      case (state_q)
        ST_CAPT: begin
          if (accept) pix_count <= pix_count + 1'b1;
          if (last_eor) begin
            state_q    <= ST_WAIT;
            frame_done <= 1'b1;
          end
        end
        ST_COUNT: begin
          if (cnt_valid) begin
            pix_count  <= cnt_value;
            frame_done <= 1'b1;
            state_q    <= ST_WAIT;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/aer_frame_capture.sv
module aer_frame_capture
  import aer_capture_pkg::*;
#(
  parameter int COLS        = 128,
  parameter int ROWS        = 64,
  parameter int EV_PER_WORD = 2,
  localparam int COL_W      = $clog2(COLS),
  localparam int ROW_W      = $clog2(ROWS),
  localparam int PIX_W      = $clog2(COLS * ROWS + 1),
  localparam int WORD_W     = EV_PER_WORD * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_active,
  input  logic              frame_start,
  input  logic              ev_valid,
  input  logic [COL_W-1:0]  ev_col,
  input  logic              ev_sign,
  input  logic              eor,
  input  logic              cnt_valid,
  input  logic [PIX_W-1:0]  cnt_value,
  input  logic              fifo_full,
  output logic              fifo_wr_en,
  output logic [WORD_W-1:0] fifo_wr_data,
  output logic [PIX_W-1:0]  pix_count,
  output logic              frame_done,
  output logic              overflow
);
  logic             capturing;
  logic             accept;
  logic             last_eor;
  logic             word_ready;
  logic [ROW_W-1:0] row;
  logic [HALF_W-1:0] ev_half;

  assign ev_half = pack_event(int'(row), int'(ev_col), ev_sign, COL_W);

  aer_capture_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_active(mode_active),
    .frame_start(frame_start), .ev_valid(ev_valid), .last_eor(last_eor),
    .cnt_valid(cnt_valid), .cnt_value(cnt_value), .capturing(capturing),
    .accept(accept), .pix_count(pix_count), .frame_done(frame_done)
  );

  aer_row_tracker #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .clear(frame_start),
    .advance(capturing && eor), .row(row), .last_eor(last_eor)
  );

  aer_event_packer #(.EV_PER_WORD(EV_PER_WORD)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .push(accept),
    .ev_half(ev_half), .flush(last_eor), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .overflow(overflow), .word_ready(word_ready)
  );
endmodule

// File: rtl/aer_capture_checker.sv
module aer_capture_checker #(
  parameter int PIX_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             fifo_full,
  input logic             capturing,
  input logic             ev_valid,
  input logic             last_eor,
  input logic             word_ready,
  input logic             fifo_wr_en,
  input logic             overflow,
  input logic             frame_done,
  input logic [PIX_W-1:0] pix_count
);
  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_eor |=> frame_done);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_start) |=> frame_done);
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && fifo_full) |=> (!fifo_wr_en && overflow));
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !frame_start) |=> overflow);
  // R4
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capturing |=> !fifo_wr_en);
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && ev_valid) |=> (pix_count == PIX_W'($past(pix_count) + 1'b1)));
endmodule

bind aer_frame_capture aer_capture_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fifo_full(fifo_full),
  .capturing(capturing), .ev_valid(ev_valid), .last_eor(last_eor),
  .word_ready(word_ready), .fifo_wr_en(fifo_wr_en), .overflow(overflow),
  .frame_done(frame_done), .pix_count(pix_count)
);

// File: tb/test_aer_frame_capture.sv
`timescale 1ns/1ps
module test_aer_frame_capture;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_active = 0, frame_start = 0, ev_valid = 0, ev_sign = 0;
  logic [6:0]  ev_col = 0;
  logic        eor = 0, cnt_valid = 0, fifo_full = 0;
  logic [13:0] cnt_value = 0;
  logic        fifo_wr_en, frame_done, overflow;
  logic [31:0] fifo_wr_data;
  logic [13:0] pix_count;

  int checks = 0, errors = 0;
  int ngot = 0;
  logic [31:0] got [0:63];
  bit finished = 0;

  always #10 clk = ~clk;

  aer_frame_capture i_aer_frame_capture (
    .clk(clk), .rst_n(rst_n), .mode_active(mode_active), .frame_start(frame_start),
    .ev_valid(ev_valid), .ev_col(ev_col), .ev_sign(ev_sign), .eor(eor),
    .cnt_valid(cnt_valid), .cnt_value(cnt_value), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .pix_count(pix_count),
    .frame_done(frame_done), .overflow(overflow)
  );

  always @(negedge clk) if (rst_n && fifo_wr_en && ngot < 64) begin
    got[ngot] = fifo_wr_data;
    ngot++;
  end

  function automatic logic [15:0] h(input int row, input int col, input bit s);
    logic [5:0] r6; logic [6:0] c7;
    r6 = row[5:0]; c7 = col[6:0];
    return {2'b00, r6, c7, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); @(negedge clk); #1; endtask

  task automatic start(input bit act);
    mode_active = act; frame_start = 1; tick(); frame_start = 0;
  endtask
  task automatic ev(input int c, input bit s);
    ev_valid = 1; ev_col = 7'(c); ev_sign = s; tick(); ev_valid = 0;
  endtask
  task automatic rows(input int n);
    for (int i = 0; i < n; i++) begin eor = 1; tick(); eor = 0; end
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; settle();
    check("R1 wr_en", fifo_wr_en, 0);
    check("R1 done", frame_done, 0);
    check("R1 overflow", overflow, 0);
    check("R1 count", pix_count, 0);
    ev(4, 1); rows(2); settle();
    check("R4 before start writes", ngot, 0);
    check("R4 before start count", pix_count, 0);
  endtask

  task automatic t_basic();
    int base = ngot;
    start(1);
    ev(5, 1); ev(10, 0); rows(2); ev(127, 1); rows(61);
    settle();
    check("R5 not done after 63 rows", frame_done, 0);
    check("R2 one word", ngot - base, 1);
    check("R2 word layout", got[base], {h(0, 5, 1), h(0, 10, 0)});
    rows(1); settle();
    check("R5 done after 64 rows", frame_done, 1);
    check("R6 flush count", ngot - base, 2);
    check("R6 padded word", got[base+1], {h(2, 127, 1), 16'hFFFF});
    check("R8 event count", pix_count, 3);
  endtask

  task automatic t_after_done();
    int base = ngot;
    ev(3, 1); ev(6, 0); rows(3); settle();
    check("R4 after done writes", ngot - base, 0);
    check("R4 after done count", pix_count, 3);
    check("R5 done held", frame_done, 1);
  endtask

  task automatic t_coincident();
    int base = ngot;
    start(1);
    rows(4);
    ev_valid = 1; ev_col = 7; ev_sign = 0; eor = 1; tick(); ev_valid = 0; eor = 0;
    ev(8, 1);
    rows(59); settle();
    check("R3 coincident row", got[base], {h(4, 7, 0), h(5, 8, 1)});
    check("R6 no flush when empty", ngot - base, 1);
    check("R5 done", frame_done, 1);
  endtask

  task automatic t_overflow();
    int base = ngot;
    start(1);
    fifo_full = 1; ev(1, 1); ev(2, 1); fifo_full = 0; settle();
    check("R7 dropped word", ngot - base, 0);
    check("R7 overflow set", overflow, 1);
    ev(3, 0); ev(4, 0); settle();
    check("R7 later word written", got[base], {h(0, 3, 0), h(0, 4, 0)});
    check("R7 overflow sticky", overflow, 1);
    check("R8 dropped counted", pix_count, 4);
    rows(64);
    start(1); settle();
    check("R7 cleared by start", overflow, 0);
    check("R8 cleared by start", pix_count, 0);
    rows(64);
  endtask

  task automatic t_idle();
    int base = ngot;
    start(0);
    ev(9, 1); rows(64); settle();
    check("R9 no done without total", frame_done, 0);
    check("R9 no events counted", pix_count, 0);
    cnt_value = 14'd777; cnt_valid = 1; tick(); cnt_valid = 0; settle();
    check("R9 total latched", pix_count, 777);
    check("R9 done", frame_done, 1);
    check("R9 no writes", ngot - base, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_after_done();
    t_coincident();
    t_overflow();
    t_idle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule